// File: doc/BRIEF.md
# Parallel flash command decoder

This block is the command front end of a byte-wide parallel flash device. It watches synchronous bus write cycles. It recognises the multi-cycle unlock-and-command sequences that software uses to talk to the device. It keeps the device either in array-read mode, where reads return the storage array's byte, or in identifier mode, where reads return a fixed manufacturer or device code.

Accepted program, sector-erase and chip-erase sequences turn into a single request pulse toward the embedded-operation engine. The pulse carries the latched address and data. Command writes never reach the array directly. While the engine reports busy, the decoder ignores every write. A separate `id_force` input stands in for the pin-level way of forcing identifier mode.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in array-read mode with `id_active` low, `req_vld` low and `rdata` equal to 0x00.
- R2: In array-read mode, a read (`rd_vld` high) loads `rdata` with `arr_rdata` one cycle later, and `rdata` holds that value until the next read.
- R3: The write sequence 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555 enters identifier mode (`id_active` high). Unlock and command addresses are compared on `addr[10:0]` only.
- R4: In identifier mode, a read with `addr[0]`=0 returns 0xAD and a read with `addr[0]`=1 returns 0x40. The mode persists across any number of reads.
- R5: A single write of 0xF0 to any address leaves identifier mode and cancels any partly received sequence. The one exception is the program-data cycle (see R8).
- R6: The three-cycle sequence 0xAA to 0x555, 0x55 to 0x2AA, 0xF0 to 0x555 also returns the block to array-read mode.
- R7: While `id_force` is high, `id_active` is high and reads return identifier codes whatever the command state.
- R8: The sequence 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555 is followed by one more write of any address and data, 0xF0 included. That write produces a request with `req_op`=0 carrying that address and data.
- R9: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to any address, produces a request with `req_op`=1. Its `req_addr` keeps `addr[18:16]` (the 64 KiB sector number) and has bits [15:0] cleared.
- R10: The same erase prefix followed by 0x10 to 0x555 produces a request with `req_op`=2 and `req_addr`=0.
- R11: A write that does not match the expected next step ends the sequence without a request. The decoder goes back to waiting for a first unlock cycle, and the current mode is kept.
- R12: While `eng_busy` is high, writes are ignored entirely: they produce no request, cause no mode change, and do not advance or reset the sequence.
- R13: Each accepted program or erase gives `req_vld` high for exactly one cycle, in the cycle after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld | input | 1 | Bus write cycle |
| rd_vld | input | 1 | Bus read cycle |
| addr | input | 19 | Bus byte address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered read data |
| arr_rdata | input | 8 | Byte from the storage array |
| id_force | input | 1 | Forces identifier mode |
| id_active | output | 1 | Identifier mode is in effect |
| eng_busy | input | 1 | Operation engine busy |
| req_vld | output | 1 | One-cycle operation request |
| req_op | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| req_addr | output | 19 | Latched target address |
| req_data | output | 8 | Latched command data |

## Verification
The bench drives a broken unlock sequence from array mode and then writes the identifier opcode alone. A decoder that fails to drop back to idle would wrongly enter identifier mode. It writes 0xF0 as program data, which a decoder that gives the reset priority would lose. It holds the engine busy in the middle of a sequence, where a design that resets the sequence on ignored writes would miss the later identifier command. It also checks that erase requests keep only the sector bits, and that identifier mode survives an aborted sequence.

// File: rtl/flash_cmd_pkg.sv
// Shared types and constants of the flash command decoder.
// Assumes an 8-bit bus and 11-bit unlock address comparison.
package flash_cmd_pkg;
    localparam int CMP_W = 11;
    localparam logic [CMP_W-1:0] UNLK_A = 11'h555;
    localparam logic [CMP_W-1:0] UNLK_B = 11'h2AA;

    localparam logic [7:0] D_UNLK1 = 8'hAA;
    localparam logic [7:0] D_UNLK2 = 8'h55;
    localparam logic [7:0] D_RESET = 8'hF0;
    localparam logic [7:0] D_IDENT = 8'h90;
    localparam logic [7:0] D_PROG  = 8'hA0;
    localparam logic [7:0] D_ERSU  = 8'h80;
    localparam logic [7:0] D_CHIP  = 8'h10;
    localparam logic [7:0] D_SECT  = 8'h30;

    typedef enum logic [2:0] {
        S_IDLE, S_UL1, S_UL2, S_PGM, S_ER0, S_ER1, S_ER2
    } seq_st_t;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2
    } op_t;
endpackage

// File: rtl/flash_seq_fsm.sv
// Sequence decoder: tracks unlock/command cycles and the sticky
// identifier mode. Assumes writes are one-cycle pulses; writes while
// busy are dropped before they reach the state.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              id_cmd,
    output logic              go_prog,
    output logic              go_sect,
    output logic              go_chip
);
    seq_st_t st, nxt;
    logic    accept, hit_a, hit_b, set_id, clr_id;

    assign accept = wr_vld && !busy;
    assign hit_a  = (addr[CMP_W-1:0] == UNLK_A);
    assign hit_b  = (addr[CMP_W-1:0] == UNLK_B);

    // Next-state and command-strobe decode for one accepted write.
    always_comb begin
        nxt     = st;
        set_id  = 1'b0;
        clr_id  = 1'b0;
        go_prog = 1'b0;
        go_sect = 1'b0;
        go_chip = 1'b0;
        if (accept) begin
            if (wdata == D_RESET && st != S_PGM) begin
                clr_id = 1'b1;
                nxt    = S_IDLE;
            end else begin
                nxt = S_IDLE;
                case (st)
                    S_IDLE: if (wdata == D_UNLK1 && hit_a) nxt = S_UL1;
                    S_UL1:  if (wdata == D_UNLK2 && hit_b) nxt = S_UL2;
                    S_UL2: begin
                        if (hit_a) begin
                            if (wdata == D_IDENT) set_id = 1'b1;
                            if (wdata == D_PROG)  nxt = S_PGM;
                            if (wdata == D_ERSU)  nxt = S_ER0;
                        end
                    end
                    S_PGM:  go_prog = 1'b1;
                    S_ER0:  if (wdata == D_UNLK1 && hit_a) nxt = S_ER1;
                    S_ER1:  if (wdata == D_UNLK2 && hit_b) nxt = S_ER2;
                    S_ER2: begin
                        if (wdata == D_SECT)               go_sect = 1'b1;
                        else if (wdata == D_CHIP && hit_a) go_chip = 1'b1;
                    end
                    default: nxt = S_IDLE;
                endcase
            end
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Sticky identifier mode entered by command, cleared by reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)      id_cmd <= 1'b0;
        else if (set_id) id_cmd <= 1'b1;
        else if (clr_id) id_cmd <= 1'b0;
    end
endmodule

// File: rtl/flash_req_gen.sv
// Request register: turns a decoded operation strobe into a one-cycle
// request with latched address and data. Assumes at most one strobe.
module flash_req_gen
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_prog,
    input  logic              go_sect,
    input  logic              go_chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              req_vld,
    output logic [1:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    localparam int OFS_W = ADDR_W - SECT_W;

    // Registers the request fields for the cycle after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld  <= 1'b0;
            req_op   <= OP_PROG;
            req_addr <= '0;
            req_data <= '0;
        end else begin
            req_vld <= go_prog | go_sect | go_chip;
            if (go_prog) begin
                req_op   <= OP_PROG;
                req_addr <= addr;
                req_data <= wdata;
            end else if (go_sect) begin
                req_op   <= OP_SECT;
                req_addr <= {addr[ADDR_W-1 -: SECT_W], {OFS_W{1'b0}}};
                req_data <= wdata;
            end else if (go_chip) begin
                req_op   <= OP_CHIP;
                req_addr <= '0;
                req_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/flash_id_rd.sv
// Read data path: returns identifier codes in identifier mode, array
// data otherwise. Output is registered and held between reads.
module flash_id_rd #(
    parameter int         DATA_W = 8,
    parameter logic [7:0] MFR_ID = 8'hAD,
    parameter logic [7:0] DEV_ID = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic              sel_b0,
    input  logic              id_mode,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata
);
    // Captures the selected byte on each read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_vld)  rdata <= id_mode ? (sel_b0 ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID))
                                           : arr_rdata;
    end
endmodule

// File: rtl/flash_cmd_if.sv
// Top of the flash command decoder. Joins sequence decoding, request
// generation and the read path. Assumes a single bus cycle per clock.
module flash_cmd_if #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              id_force,
    output logic              id_active,
    input  logic              eng_busy,
    output logic              req_vld,
    output logic [1:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    logic id_cmd, go_prog, go_sect, go_chip;

    assign id_active = id_cmd | id_force;

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .busy(eng_busy),
        .addr(addr), .wdata(wdata), .id_cmd(id_cmd),
        .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip)
    );

    flash_req_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_sect(go_sect),
        .go_chip(go_chip), .addr(addr), .wdata(wdata),
        .req_vld(req_vld), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data)
    );

    flash_id_rd #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .sel_b0(addr[0]),
        .id_mode(id_active), .arr_rdata(arr_rdata), .rdata(rdata)
    );
endmodule

// File: rtl/flash_cmd_if_chk.sv
// Property checker for flash_cmd_if, attached by bind below.
module flash_cmd_if_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_vld,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              id_force,
    input logic              id_active,
    input logic              eng_busy,
    input logic              req_vld,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> !req_vld); // R13
    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) eng_busy |=> !req_vld); // R12
    AST_FORCE_ID: assert property (@(posedge clk) disable iff (!rst_n) id_force |-> id_active); // R7
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && id_active) |=> rdata == ($past(addr[0]) ? 8'h40 : 8'hAD)); // R4
    AST_ARRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !id_active) |=> rdata == $past(arr_rdata)); // R2
    AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd1) |-> req_addr[ADDR_W-4:0] == '0); // R9
    AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd2) |-> req_addr == '0); // R10
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .addr(addr), .rdata(rdata),
    .arr_rdata(arr_rdata), .id_force(id_force), .id_active(id_active),
    .eng_busy(eng_busy), .req_vld(req_vld), .req_op(req_op), .req_addr(req_addr)
);

// File: tb/flash_cmd_if_tb_top.sv
// Directed bench for flash_cmd_if: one task per scenario.
module flash_cmd_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld = 1'b0, rd_vld = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0, arr_rdata = 8'h5C;
    logic        id_force = 1'b0, eng_busy = 1'b0;
    logic [7:0]  rdata, req_data;
    logic        id_active, req_vld;
    logic [1:0]  req_op;
    logic [18:0] req_addr;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    flash_cmd_if dut_i (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .rd_vld(rd_vld),
        .addr(addr), .wdata(wdata), .rdata(rdata), .arr_rdata(arr_rdata),
        .id_force(id_force), .id_active(id_active), .eng_busy(eng_busy),
        .req_vld(req_vld), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_vld = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a);
        @(negedge clk);
        rd_vld = 1'b1; addr = a;
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic unlock();
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
    endtask

    task automatic t_reset();
        chk("R1 id_active", id_active, 0);
        chk("R1 req_vld", req_vld, 0);
        chk("R1 rdata", rdata, 8'h00);
    endtask

    task automatic t_array();
        arr_rdata = 8'h3E; rd(19'h00001);
        chk("R2 array read", rdata, 8'h3E);
        arr_rdata = 8'h11; @(negedge clk);
        chk("R2 hold", rdata, 8'h3E);
    endtask

    task automatic t_ident();
        unlock(); wr(19'h555, 8'h90);
        chk("R3 id entry", id_active, 1);
        rd(19'h7FF00); chk("R4 mfr code", rdata, 8'hAD);
        rd(19'h00001); chk("R4 dev code", rdata, 8'h40);
        for (int i = 0; i < 4; i++) rd(19'h00000);
        chk("R4 persists", id_active, 1);
        wr(19'h1234, 8'hF0);
        chk("R5 single reset", id_active, 0);
        rd(19'h00001); chk("R5 array after reset", rdata, arr_rdata);
    endtask

    task automatic t_full_reset();
        unlock(); wr(19'h555, 8'h90);
        unlock(); wr(19'h555, 8'hF0);
        chk("R6 full reset", id_active, 0);
    endtask

    task automatic t_force();
        id_force = 1'b1;
        rd(19'h00001); chk("R7 forced dev code", rdata, 8'h40);
        chk("R7 id_active", id_active, 1);
        id_force = 1'b0; @(negedge clk);
        chk("R7 release", id_active, 0);
    endtask

    task automatic t_program();
        unlock(); wr(19'h555, 8'hA0);
        wr(19'h4ABCD, 8'h5A);
        chk("R8 req_vld", req_vld, 1);
        chk("R8 op", req_op, 0);
        chk("R8 addr", req_addr, 19'h4ABCD);
        chk("R8 data", req_data, 8'h5A);
        @(negedge clk); chk("R13 single pulse", req_vld, 0);
        unlock(); wr(19'h555, 8'hA0);
        wr(19'h00010, 8'hF0);
        chk("R8 F0 as data", req_vld, 1);
        chk("R8 F0 data", req_data, 8'hF0);
    endtask

    task automatic t_erase(input bit chip);
        unlock(); wr(19'h555, 8'h80); unlock();
        if (chip) begin
            wr(19'h555, 8'h10);
            chk("R10 req_vld", req_vld, 1);
            chk("R10 op", req_op, 2);
            chk("R10 addr", req_addr, 0);
        end else begin
            wr(19'h5BEEF, 8'h30);
            chk("R9 req_vld", req_vld, 1);
            chk("R9 op", req_op, 1);
            chk("R9 sector addr", req_addr, 19'h50000);
        end
        @(negedge clk); chk("R13 erase pulse", req_vld, 0);
    endtask

    task automatic t_abort();
        wr(19'h555, 8'hAA); wr(19'h123, 8'h55);
        chk("R11 no req", req_vld, 0);
        wr(19'h555, 8'h90);
        chk("R11 back to idle", id_active, 0);
        unlock(); wr(19'h555, 8'h90);
        unlock(); wr(19'h555, 8'h77);
        chk("R11 mode kept", id_active, 1);
        unlock(); wr(19'h555, 8'h80); wr(19'h555, 8'h12);
        chk("R11 erase abort", req_vld, 0);
        wr(19'h0, 8'hF0);
    endtask

    task automatic t_busy();
        unlock();
        eng_busy = 1'b1;
        wr(19'h555, 8'h90);
        chk("R12 busy ignored", id_active, 0);
        wr(19'h555, 8'h33);
        eng_busy = 1'b0;
        wr(19'h555, 8'h90);
        chk("R12 seq kept", id_active, 1);
        eng_busy = 1'b1;
        wr(19'h0, 8'hF0);
        chk("R12 reset ignored", id_active, 1);
        unlock(); wr(19'h555, 8'hA0); wr(19'h1, 8'h1);
        chk("R12 no request", req_vld, 0);
        eng_busy = 1'b0;
        wr(19'h0, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_array();
        t_ident();
        t_full_reset();
        t_force();
        t_program();
        t_erase(1'b0);
        t_erase(1'b1);
        t_abort();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule